// File: doc/BRIEF.md
# Lockable Timestamp Counter

This block keeps the system time as two fields: a 32-bit count of whole seconds and a 16-bit sub-second count. One sub-second unit is 32 µs, so 31250 units make one second. A one-cycle enable, `tick_i`, marks each 32 µs step. The host changes the block's state through a single write port. A 2-bit select picks one of three targets: the seconds value, the clock-configuration byte, or the calibration offset.

Software can load a new seconds value only while the counter is unlocked. Lock and unlock requests come from bits of the clock-configuration byte. A calibration offset, counted in 500 µs steps, is folded into the reported time, and a carry passes into the reported seconds. When the heartbeat is enabled, the block raises a one-cycle pulse at each whole-second rollover. The pulse comes with the new seconds value.

Top module: `ts_keeper`

## Requirements
- R1: On each cycle with `tick_i` high, the raw sub-second count advances by one from 0 up to 31249. The tick after 31249 returns it to 0 and adds one to the seconds count.
- R2: After `rst_ni` is asserted, the seconds count is 0, the sub-second count is 0, the offset is 0, `locked_o` is 0 and `unlocked_o` is 1.
- R3: A write with select 1 (clock configuration) acts on three bits. A 1 in bit 7 locks the counter. A 1 in bit 6, or a 1 in bit 0 (the repeat request), unlocks it. When bit 7 and an unlock bit are both set, the lock wins. `locked_o` and `unlocked_o` always show the current state.
- R4: A write with select 0 while unlocked loads `wr_data_i` into the seconds count and clears the sub-second count to 0, effective at the next clock.
- R5: A write with select 0 while locked is rejected. Seconds and sub-second counts keep their values.
- R6: A write with select 2 stores `wr_data_i[7:0]` as the offset in 500 µs steps. The reported sub-second count is the raw count plus round(offset × 15.625), taken modulo 31250. On overflow, the reported seconds are the raw seconds plus one.
- R7: When a rollover happens while `hb_en_i` is high, `hb_o` is high for exactly the next cycle, and `hb_sec_o` then holds the new raw seconds value. A rollover with `hb_en_i` low gives no pulse.
- R8: An accepted seconds load in the same cycle as a tick at 31249 takes priority. The result is the loaded seconds and a raw sub-second count of 0, with no increment and no heartbeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32 µs step enable |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 seconds, 1 clock configuration, 2 offset, 3 ignored |
| wr_data_i | input | 32 | Write data |
| hb_en_i | input | 1 | Heartbeat enable |
| sec_o | output | 32 | Reported seconds (offset applied) |
| sub_o | output | 16 | Reported sub-second count, 32 µs units (offset applied) |
| locked_o | output | 1 | Counter is locked |
| unlocked_o | output | 1 | Counter is unlocked |
| hb_o | output | 1 | One-cycle heartbeat pulse |
| hb_sec_o | output | 32 | Raw seconds carried with the heartbeat |

## Verification
A host load of the seconds value and the rollover of the sub-second count can fall in the same cycle. The bench first steps the counter to 31249 with the heartbeat enabled. It then raises `tick_i` and an unlocked seconds write on the same clock edge. The scoreboard expects the loaded seconds, a raw sub-second count of zero shown through the active offset, and an unchanged heartbeat count. Any increment or stray pulse is reported as a failure.

// File: rtl/ts_pkg.sv
package ts_pkg;
  typedef enum logic [1:0] {
    SEL_SEC = 2'd0,
    SEL_CFG = 2'd1,
    SEL_OFF = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;

  localparam int CFG_LOCK_BIT   = 7;
  localparam int CFG_UNLOCK_BIT = 6;
  localparam int CFG_REP_BIT    = 0;
endpackage

// File: rtl/ts_subsec_ctr.sv
module ts_subsec_ctr #(
  parameter int SUB_W   = 16,
  parameter int SUB_MAX = 31249
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [SUB_W-1:0] sub_o,
  output logic             wrap_o
);
  localparam logic [SUB_W-1:0] MaxVal = SUB_W'(SUB_MAX);

  logic [SUB_W-1:0] sub_q;
  logic             at_max;

  assign at_max = (sub_q == MaxVal);
  assign wrap_o = tick_i & at_max & ~clr_i;
  assign sub_o  = sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sub_q <= '0;
    else if (clr_i)   sub_q <= '0;
    else if (tick_i)  sub_q <= at_max ? '0 : sub_q + 1'b1;
  end

  a_r1_sub_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_q <= MaxVal);
  a_r1_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (sub_q == '0));
  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && !at_max) |=> (sub_q == $past(sub_q) + 1'b1));
endmodule

// File: rtl/ts_lock_ctl.sv
module ts_lock_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_req_i,
  input  logic unlock_req_i,
  output logic locked_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           locked_q <= 1'b0;
    else if (lock_req_i)   locked_q <= 1'b1;
    else if (unlock_req_i) locked_q <= 1'b0;
  end

  assign locked_o = locked_q;

  a_r3_lock_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_req_i |=> locked_q);
  a_r3_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlock_req_i && !lock_req_i) |=> !locked_q);
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlock_req_i && !lock_req_i) |=> $stable(locked_q));
endmodule

// File: rtl/ts_offset_fold.sv
module ts_offset_fold #(
  parameter int SEC_W     = 32,
  parameter int SUB_W     = 16,
  parameter int OFF_W     = 8,
  parameter int SUB_MAX   = 31249,
  parameter int OFF_NUM   = 125,
  parameter int OFF_SHIFT = 3
) (
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [SUB_W-1:0] sub_o
);
  localparam int PROD_W = OFF_W + 8;
  localparam logic [PROD_W-1:0] Half   = PROD_W'(1 << (OFF_SHIFT - 1));
  localparam logic [SUB_W:0]    Modulo = (SUB_W+1)'(SUB_MAX + 1);

  logic [PROD_W-1:0] prod;
  logic [SUB_W-1:0]  off_units;
  logic [SUB_W:0]    sum;
  logic              carry;

  // 500 us step = 15.625 units of 32 us; round to nearest
  assign prod      = PROD_W'(off_i) * PROD_W'(OFF_NUM) + Half;
  assign off_units = SUB_W'(prod >> OFF_SHIFT);
  assign sum       = {1'b0, sub_i} + {1'b0, off_units};
  assign carry     = (sum >= Modulo);
  assign sub_o     = carry ? SUB_W'(sum - Modulo) : SUB_W'(sum);
  assign sec_o     = sec_i + SEC_W'(carry);
endmodule

// File: rtl/ts_keeper.sv
module ts_keeper #(
  parameter int SEC_W   = 32,
  parameter int SUB_W   = 16,
  parameter int OFF_W   = 8,
  parameter int DATA_W  = 32,
  parameter int SUB_MAX = 31249
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              hb_en_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [SUB_W-1:0]  sub_o,
  output logic              locked_o,
  output logic              unlocked_o,
  output logic              hb_o,
  output logic [SEC_W-1:0]  hb_sec_o
);
  import ts_pkg::*;

  logic [SEC_W-1:0] sec_q;
  logic [OFF_W-1:0] off_q;
  logic [SUB_W-1:0] sub_raw;
  logic             wrap;
  logic             locked;
  logic             we_sec, we_cfg, we_off, load_ok;
  logic             hb_q;
  logic [SEC_W-1:0] hb_sec_q;

  assign we_sec  = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_SEC);
  assign we_cfg  = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_CFG);
  assign we_off  = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_OFF);
  assign load_ok = we_sec && !locked;

  ts_subsec_ctr #(.SUB_W(SUB_W), .SUB_MAX(SUB_MAX)) i_sub (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (load_ok),
    .sub_o  (sub_raw),
    .wrap_o (wrap)
  );

  ts_lock_ctl i_lock (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lock_req_i   (we_cfg && wr_data_i[CFG_LOCK_BIT]),
    .unlock_req_i (we_cfg && (wr_data_i[CFG_UNLOCK_BIT] || wr_data_i[CFG_REP_BIT])),
    .locked_o     (locked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sec_q <= '0;
    else if (load_ok) sec_q <= SEC_W'(wr_data_i);
    else if (wrap)    sec_q <= sec_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     off_q <= '0;
    else if (we_off) off_q <= wr_data_i[OFF_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hb_q     <= 1'b0;
      hb_sec_q <= '0;
    end else begin
      hb_q <= wrap && hb_en_i;
      if (wrap && hb_en_i) hb_sec_q <= sec_q + 1'b1;
    end
  end

  ts_offset_fold #(
    .SEC_W(SEC_W), .SUB_W(SUB_W), .OFF_W(OFF_W), .SUB_MAX(SUB_MAX)
  ) i_fold (
    .sec_i (sec_q),
    .sub_i (sub_raw),
    .off_i (off_q),
    .sec_o (sec_o),
    .sub_o (sub_o)
  );

  assign locked_o   = locked;
  assign unlocked_o = !locked;
  assign hb_o       = hb_q;
  assign hb_sec_o   = hb_sec_q;

  a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ok |=> (sec_q == $past(SEC_W'(wr_data_i)) && sub_raw == '0));
  a_r5_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_sec && locked && !tick_i) |=> ($stable(sec_q) && $stable(sub_raw)));
  a_r6_sub_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_o <= SUB_W'(SUB_MAX));
  a_r7_hb_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hb_o |-> (hb_sec_o == sec_q));
  a_r7_hb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hb_o |=> !hb_o);
  a_r8_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ok && tick_i) |=> (!hb_o && sub_raw == '0));
endmodule

// File: tb/test_ts_keeper.sv
module test_ts_keeper;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'd3;
  logic [31:0] wr_data_i = '0;
  logic        hb_en_i = 1'b0;
  logic [31:0] sec_o, hb_sec_o;
  logic [15:0] sub_o;
  logic        locked_o, unlocked_o, hb_o;

  ts_keeper i_ts_keeper (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .hb_en_i(hb_en_i),
    .sec_o(sec_o), .sub_o(sub_o), .locked_o(locked_o), .unlocked_o(unlocked_o),
    .hb_o(hb_o), .hb_sec_o(hb_sec_o)
  );

  always #4 clk_i = ~clk_i;

  typedef struct {
    int unsigned sec;
    int unsigned sub;
    bit          lck;
    int unsigned hbn;
    int unsigned hbs;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          total = 0;
  int          bad = 0;
  int unsigned hb_cnt = 0;
  int unsigned hb_last = 0;
  bit          done = 0;

  // monitor: counts heartbeats, then scores queued expectations
  always @(posedge clk_i) begin
    #2;
    if (rst_ni && hb_o) begin
      hb_cnt++;
      hb_last = hb_sec_o;
    end
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (sec_o !== e.sec || sub_o !== 16'(e.sub) || locked_o !== e.lck ||
          unlocked_o !== !e.lck || hb_cnt != e.hbn || hb_last != e.hbs) begin
        bad++;
        $display("FAIL %s: sec=%0d sub=%0d lck=%0b ulk=%0b hbn=%0d hbs=%0d exp sec=%0d sub=%0d lck=%0b hbn=%0d hbs=%0d",
                 e.tag, sec_o, sub_o, locked_o, unlocked_o, hb_cnt, hb_last,
                 e.sec, e.sub, e.lck, e.hbn, e.hbs);
      end
    end
  end

  task automatic expect_st(int unsigned sec, int unsigned sub, bit lck,
                           int unsigned hbn, int unsigned hbs, string tag);
    exp_t e;
    e.sec = sec; e.sub = sub; e.lck = lck; e.hbn = hbn; e.hbs = hbs; e.tag = tag;
    q.push_back(e);
    while (q.size() > 0) @(negedge clk_i);
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_sel_i = 2'd3;
  endtask

  task automatic tick_n(int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    expect_st(0, 0, 0, 0, 0, "R2 reset state");

    wr(2'd0, 100);
    expect_st(100, 0, 0, 0, 0, "R4 load unlocked");
    tick_n(5);
    expect_st(100, 5, 0, 0, 0, "R1 count ticks");

    wr(2'd1, 32'h80);
    expect_st(100, 5, 1, 0, 0, "R3 lock bit7");
    wr(2'd0, 500);
    expect_st(100, 5, 1, 0, 0, "R5 load rejected when locked");
    wr(2'd1, 32'h01);
    expect_st(100, 5, 0, 0, 0, "R3 repeat bit unlocks");
    wr(2'd1, 32'h80);
    wr(2'd1, 32'h40);
    expect_st(100, 5, 0, 0, 0, "R3 bit6 unlocks");
    wr(2'd1, 32'hC1);
    expect_st(100, 5, 1, 0, 0, "R3 lock wins over unlock");
    wr(2'd1, 32'h40);

    wr(2'd2, 1);
    expect_st(100, 21, 0, 0, 0, "R6 offset 1 -> 16 units");
    wr(2'd2, 3);
    expect_st(100, 52, 0, 0, 0, "R6 offset 3 -> 47 units");

    wr(2'd2, 255);
    wr(2'd0, 10);
    expect_st(10, 3984, 0, 0, 0, "R6 offset 255 after R4 load");
    hb_en_i = 1'b1;
    tick_n(27270);
    expect_st(11, 4, 0, 0, 0, "R6 offset carry into seconds");
    tick_n(3979);
    expect_st(11, 3983, 0, 0, 0, "R1 raw at 31249");
    tick_n(1);
    expect_st(11, 3984, 0, 1, 11, "R7 heartbeat at rollover");

    tick_n(31249);
    expect_st(12, 3983, 0, 1, 11, "R1 second pass at 31249");
    @(negedge clk_i);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 2'd0; wr_data_i = 42;
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0; wr_sel_i = 2'd3;
    expect_st(42, 3984, 0, 1, 11, "R8 load beats rollover");

    wr(2'd2, 0);
    hb_en_i = 1'b0;
    tick_n(31250);
    expect_st(43, 0, 0, 1, 11, "R7 no heartbeat when disabled, R1 wrap");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule